// File: doc/BRIEF.md
# Half-Step Frame-Locked Line Clock Regenerator

This block rebuilds a T1 (1.544 MHz) or E1 (2.048 MHz) line clock from a free-running master oscillator and keeps it phase-locked to an external 8 kHz frame reference. The design runs on a tick clock at twice the master rate, so one tick is half a master period. A single phase counter walks through one 125 µs frame. The line clock, an internal 8 kHz square wave and a correction window (CS) are all decoded from that counter. The master clock is 12.352 MHz in T1 mode and 16.384 MHz in E1 mode. It is divided by eight to make the line clock. The line clock is then divided by 193 (T1) or 256 (E1) to make the internal 8 kHz signal.

After a two-flop synchroniser, every falling edge of the reference triggers a bang-bang judgement of phase. The result depends on the correction window and on the level of the internal 8 kHz signal at that moment:

- If the window is closed, nothing happens.
- If the window is open and the internal signal is already low, the internal timing is ahead. The counter holds for one tick, which stretches one master cycle by half a period.
- If the window is open and the internal signal is still high, the internal timing is behind. The counter jumps two ticks, which shrinks one master cycle by half a period.

At most one correction is applied per internal frame. Each correction shows up as a one-tick pulse and a direction flag. All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `halfstep_dpll`

## Requirements
- R1: While `rst_n` is low, `line_clk` = 1, `int_8k` = 1, `cs_win` = 0, `corr_pulse` = 0 and `corr_stretch` = 0.
- R2: With no corrections, `line_clk` is high for 8 ticks and then low for 8 ticks (8 master periods per line clock).
- R3: In T1 mode (`mode_e1` = 0) with no corrections, `int_8k` is high for 1544 ticks and then low for 1544 ticks (193 line clocks per frame).
- R4: In E1 mode (`mode_e1` = 1) with no corrections, `int_8k` is high for 2048 ticks and then low for 2048 ticks (256 line clocks per frame).
- R5: `cs_win` straddles each falling edge of `int_8k`:
  - In T1 mode it is high for 8 ticks (4 master periods) and rises 4 ticks before `int_8k` falls.
  - In E1 mode it is high for 1024 ticks (512 master periods) and rises 512 ticks before `int_8k` falls.
- R6: A falling edge of `ref_8k` is judged using the output values visible in the cycle after the second clock edge at which `ref_8k` is sampled low. Any resulting `corr_pulse` appears in the following cycle.
- R7: A reference falling edge judged while `cs_win` = 0 produces no `corr_pulse`.
- R8: A reference falling edge judged while `cs_win` = 1 and `int_8k` = 0 produces a one-tick `corr_pulse` with `corr_stretch` = 1, and the phase counter holds for one tick.
- R9: A reference falling edge judged while `cs_win` = 1 and `int_8k` = 1 produces a one-tick `corr_pulse` with `corr_stretch` = 0, and the phase counter advances two ticks.
- R10: Only one correction is applied per internal frame. A further in-window reference edge before `int_8k` next rises produces no `corr_pulse`.
- R11: In T1 mode, consider a reference whose period is one tick longer than the frame. Once it falls inside the window, every frame yields a stretch and the edge stays inside `cs_win`. For a reference one tick shorter than the frame, every frame yields a shrink.
- R12: No correction occurs after reset until the first falling edge of `ref_8k`. A reference held low through and after reset produces no `corr_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the master oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_8k | input | 1 | External 8 kHz frame reference, asynchronous |
| mode_e1 | input | 1 | 0 selects T1 division, 1 selects E1 division |
| line_clk | output | 1 | Regenerated line clock |
| int_8k | output | 1 | Internal 8 kHz signal, high in the first half of the frame |
| cs_win | output | 1 | Correction window around the falling edge of `int_8k` |
| corr_pulse | output | 1 | One-tick pulse for each applied correction |
| corr_stretch | output | 1 | Direction of the last correction: 1 stretch, 0 shrink |

## Verification
The correction decision and the frame divider's own advance always land in the same cycle. A hold or a double step replaces the normal single step, and this is judged by the frame lengths that follow in the two lock runs.

The sharper collision is a second reference edge inside the same E1 window, right after a shrink. The window is still open, so only the once-per-frame guard can suppress it. The bench drives that second edge a few ticks after the first and expects a silent cycle in place of a second pulse. It then expects a normal stretch on an edge in the next frame.

// File: rtl/hsdpll_pkg.sv
package hsdpll_pkg;
  typedef enum logic [1:0] {
    STEP_NORMAL  = 2'd0,
    STEP_HOLD    = 2'd1,
    STEP_SKIP    = 2'd2
  } step_e;
endpackage

// File: rtl/hsdpll_ref_edge.sv
module hsdpll_ref_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic fall_o
);
  // sh_q[0] is the newest sample; sh_q[STAGES] is the previous synchronised level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], ref_in};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/hsdpll_frame_divider.sv
module hsdpll_frame_divider
  import hsdpll_pkg::*;
#(
  parameter int TICKS_PER_LINE = 16,
  parameter int T1_FRAME       = 3088,
  parameter int E1_FRAME       = 4096,
  parameter int T1_CS_TICKS    = 8,
  parameter int E1_CS_TICKS    = 1024,
  parameter int PHASE_W        = 13
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_e1,
  input  step_e step_i,
  output logic  wrap_o,
  output logic  line_clk_o,
  output logic  int_8k_o,
  output logic  cs_win_o
);
  localparam int LINE_BIT = $clog2(TICKS_PER_LINE) - 1;

  logic [PHASE_W-1:0] phase_q, sum, frame_len, half_len, cs_lo, cs_hi;
  logic [1:0]         step;

  always_comb begin
    if (mode_e1) begin
      frame_len = PHASE_W'(E1_FRAME);
      half_len  = PHASE_W'(E1_FRAME / 2);
      cs_lo     = PHASE_W'(E1_FRAME / 2 - E1_CS_TICKS / 2);
      cs_hi     = PHASE_W'(E1_FRAME / 2 + E1_CS_TICKS / 2);
    end else begin
      frame_len = PHASE_W'(T1_FRAME);
      half_len  = PHASE_W'(T1_FRAME / 2);
      cs_lo     = PHASE_W'(T1_FRAME / 2 - T1_CS_TICKS / 2);
      cs_hi     = PHASE_W'(T1_FRAME / 2 + T1_CS_TICKS / 2);
    end
  end

  always_comb begin
    case (step_i)
      STEP_HOLD: step = 2'd0;
      STEP_SKIP: step = 2'd2;
      default:   step = 2'd1;
    endcase
  end

  assign sum    = phase_q + PHASE_W'(step);
  assign wrap_o = (sum >= frame_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (wrap_o) phase_q <= sum - frame_len;
    else             phase_q <= sum;
  end

  assign line_clk_o = ~phase_q[LINE_BIT];
  assign int_8k_o   = (phase_q < half_len);
  assign cs_win_o   = (phase_q >= cs_lo) && (phase_q < cs_hi);
endmodule

// File: rtl/hsdpll_phase_judge.sv
module hsdpll_phase_judge
  import hsdpll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_fall,
  input  logic  int_8k,
  input  logic  cs_win,
  input  logic  wrap,
  output step_e step_o,
  output logic  corr_pulse_o,
  output logic  corr_stretch_o
);
  logic used_q;

  always_comb begin
    step_o = STEP_NORMAL;
    if (ref_fall && cs_win && !used_q)
      step_o = int_8k ? STEP_SKIP : STEP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q         <= 1'b0;
      corr_pulse_o   <= 1'b0;
      corr_stretch_o <= 1'b0;
    end else begin
      corr_pulse_o <= (step_o != STEP_NORMAL);
      if (step_o != STEP_NORMAL) begin
        used_q         <= 1'b1;
        corr_stretch_o <= (step_o == STEP_HOLD);
      end else if (wrap) begin
        used_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/halfstep_dpll.sv
module halfstep_dpll
  import hsdpll_pkg::*;
#(
  parameter int MASTER_PER_LINE = 8,
  parameter int T1_LINES        = 193,
  parameter int E1_LINES        = 256,
  parameter int T1_CS_MASTERS   = 4,
  parameter int E1_CS_MASTERS   = 512,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_8k,
  input  logic mode_e1,
  output logic line_clk,
  output logic int_8k,
  output logic cs_win,
  output logic corr_pulse,
  output logic corr_stretch
);
  localparam int TICKS_PER_LINE = 2 * MASTER_PER_LINE;
  localparam int T1_FRAME       = TICKS_PER_LINE * T1_LINES;
  localparam int E1_FRAME       = TICKS_PER_LINE * E1_LINES;
  localparam int MAX_FRAME      = (T1_FRAME > E1_FRAME) ? T1_FRAME : E1_FRAME;
  localparam int PHASE_W        = $clog2(MAX_FRAME + 3);

  logic  ref_fall, wrap;
  step_e step;

  hsdpll_ref_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_8k), .fall_o(ref_fall)
  );

  hsdpll_frame_divider #(
    .TICKS_PER_LINE(TICKS_PER_LINE),
    .T1_FRAME(T1_FRAME),
    .E1_FRAME(E1_FRAME),
    .T1_CS_TICKS(2 * T1_CS_MASTERS),
    .E1_CS_TICKS(2 * E1_CS_MASTERS),
    .PHASE_W(PHASE_W)
  ) div_i (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .step_i(step),
    .wrap_o(wrap), .line_clk_o(line_clk), .int_8k_o(int_8k), .cs_win_o(cs_win)
  );

  hsdpll_phase_judge judge_i (
    .clk(clk), .rst_n(rst_n), .ref_fall(ref_fall), .int_8k(int_8k),
    .cs_win(cs_win), .wrap(wrap), .step_o(step),
    .corr_pulse_o(corr_pulse), .corr_stretch_o(corr_stretch)
  );
endmodule

// File: rtl/hsdpll_checker.sv
module hsdpll_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_fall,
  input logic int_8k,
  input logic cs_win,
  input logic corr_pulse,
  input logic corr_stretch
);
  AST_WINDOW_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_8k) |-> cs_win); // R5

  AST_PULSE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_pulse |-> $past(ref_fall)); // R6

  AST_PULSE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    corr_pulse |-> $past(cs_win)); // R7

  AST_STRETCH_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_pulse && corr_stretch) |-> !$past(int_8k)); // R8

  AST_SHRINK_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_pulse && !corr_stretch) |-> $past(int_8k)); // R9

  AST_SINGLE_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_pulse |=> !corr_pulse); // R10
endmodule

bind halfstep_dpll hsdpll_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ref_fall(ref_fall), .int_8k(int_8k),
  .cs_win(cs_win), .corr_pulse(corr_pulse), .corr_stretch(corr_stretch)
);

// File: tb/halfstep_dpll_tb_top.sv
module halfstep_dpll_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_8k = 1'b0;
  logic mode_e1 = 1'b0;
  logic line_clk, int_8k, cs_win, corr_pulse, corr_stretch;

  always #5 clk = ~clk;

  halfstep_dpll dut_i (
    .clk(clk), .rst_n(rst_n), .ref_8k(ref_8k), .mode_e1(mode_e1),
    .line_clk(line_clk), .int_8k(int_8k), .cs_win(cs_win),
    .corr_pulse(corr_pulse), .corr_stretch(corr_stretch)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned due;
    int          kind;   // 0 none, 1 stretch, 2 shrink
    string       req;
  } exp_t;

  exp_t q[$];
  int n_checks = 0, n_fail = 0;
  int frame_id = 0, used_frame = -1;
  int stretch_cnt = 0, shrink_cnt = 0, pulse_total = 0;
  bit mon_prev_int = 1'b1;
  bit last_cs;

  localparam int SIG_INT = 0, SIG_CS = 1, SIG_LINE = 2;

  function automatic bit sig(int sel);
    case (sel)
      SIG_INT: return int_8k;
      SIG_CS:  return cs_win;
      default: return line_clk;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  task automatic wait_rise(int sel);
    bit prev;
    prev = sig(sel);
    forever begin
      @(negedge clk);
      if (sig(sel) && !prev) break;
      prev = sig(sel);
    end
  endtask

  task automatic count_level(int sel, bit lvl, output int n);
    n = 0;
    while (sig(sel) == lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  // driver: one reference falling edge, expected outcome into the scoreboard
  task automatic ref_edge();
    exp_t it;
    ref_8k = 1'b0;
    @(negedge clk);
    @(negedge clk);
    it.due = cyc + 1;
    last_cs = cs_win;
    if (!cs_win) begin
      it.kind = 0; it.req = "R7";
    end else if (used_frame == frame_id) begin
      it.kind = 0; it.req = "R10";
    end else begin
      it.kind = int_8k ? 2 : 1;
      it.req  = int_8k ? "R9" : "R8";
      used_frame = frame_id;
    end
    q.push_back(it);
    @(negedge clk);
    ref_8k = 1'b1;
  endtask

  task automatic lock_run(int period, int lead, int frames, int tail, bit want_stretch);
    int s0, h0, cs_in;
    s0 = 0; h0 = 0; cs_in = 0;
    wait_rise(SIG_INT);
    repeat (lead) @(negedge clk);
    for (int f = 0; f < frames; f++) begin
      if (f == frames - tail) begin
        s0 = stretch_cnt; h0 = shrink_cnt;
      end
      ref_edge();
      if (f >= frames - tail && last_cs) cs_in++;
      repeat (period - 3) @(negedge clk);
    end
    check(cs_in == tail, "R11", "lock edges inside window", cs_in, tail);
    check(stretch_cnt - s0 == (want_stretch ? tail : 0), "R11", "lock stretch count",
          stretch_cnt - s0, want_stretch ? tail : 0);
    check(shrink_cnt - h0 == (want_stretch ? 0 : tail), "R11", "lock shrink count",
          shrink_cnt - h0, want_stretch ? 0 : tail);
  endtask

  task automatic measure(int hi_exp, int lead_exp, int cs_exp, string req_f);
    int n, both, ncs;
    wait_rise(SIG_INT);
    count_level(SIG_INT, 1'b1, n);
    check(n == hi_exp, req_f, "int_8k high ticks", n, hi_exp);
    count_level(SIG_INT, 1'b0, n);
    check(n == hi_exp, req_f, "int_8k low ticks", n, hi_exp);
    wait_rise(SIG_CS);
    both = 0; ncs = 0;
    while (cs_win) begin
      ncs++;
      if (int_8k) both++;
      @(negedge clk);
    end
    check(both == lead_exp, "R5", "window lead before int_8k fall", both, lead_exp);
    check(ncs == cs_exp, "R5", "window width", ncs, cs_exp);
  endtask

  initial begin
    int n;
    fork
      begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
      end
      begin : monitor
        exp_t it;
        forever begin
          @(negedge clk);
          if (rst_n) begin
            if (int_8k && !mon_prev_int) frame_id++;
            mon_prev_int = int_8k;
            if (corr_pulse) pulse_total++;
            if (q.size() > 0 && q[0].due == cyc) begin
              it = q.pop_front();
              check(corr_pulse == (it.kind != 0), it.req, "correction pulse (R6 timing)",
                    corr_pulse, it.kind != 0);
              if (it.kind != 0 && corr_pulse) begin
                check(corr_stretch == (it.kind == 1), it.req, "correction direction",
                      corr_stretch, it.kind == 1);
                if (corr_stretch) stretch_cnt++; else shrink_cnt++;
              end
            end else if (corr_pulse) begin
              check(1'b0, "R7", "unexpected correction pulse", 1, 0);
            end
          end
        end
      end
    join_none

    // R1 reset values
    repeat (4) @(negedge clk);
    check(line_clk == 1'b1, "R1", "line_clk in reset", line_clk, 1);
    check(int_8k == 1'b1, "R1", "int_8k in reset", int_8k, 1);
    check(cs_win == 1'b0, "R1", "cs_win in reset", cs_win, 0);
    check(corr_pulse == 1'b0, "R1", "corr_pulse in reset", corr_pulse, 0);
    check(corr_stretch == 1'b0, "R1", "corr_stretch in reset", corr_stretch, 0);
    rst_n = 1'b1;

    // R12 reference held low since reset: no edge, no correction
    repeat (3200) @(negedge clk);
    check(pulse_total == 0, "R12", "pulses with reference held low", pulse_total, 0);
    ref_8k = 1'b1;
    repeat (8) @(negedge clk);

    // R2 line clock
    wait_rise(SIG_LINE);
    count_level(SIG_LINE, 1'b1, n);
    check(n == 8, "R2", "line_clk high ticks", n, 8);
    count_level(SIG_LINE, 1'b0, n);
    check(n == 8, "R2", "line_clk low ticks", n, 8);

    // R3 / R5 T1 frame and window
    measure(1544, 4, 8, "R3");

    // R11 lock, slower then faster reference
    lock_run(3089, 1534, 18, 10, 1'b1);
    lock_run(3087, 1550, 18, 10, 1'b0);

    // R4 / R5 E1 frame and window
    mode_e1 = 1'b1;
    wait_rise(SIG_INT);
    measure(2048, 512, 1024, "R4");

    // E1 edges: outside window, shrink, second edge same frame, stretch next frame
    wait_rise(SIG_INT);
    repeat (498) @(negedge clk);
    ref_edge();                      // R7 sampled at tick 500
    repeat (1497) @(negedge clk);
    ref_edge();                      // R9 sampled at tick 2000
    repeat (5) @(negedge clk);
    ref_edge();                      // R10 suppressed
    wait_rise(SIG_INT);
    repeat (2298) @(negedge clk);
    ref_edge();                      // R8 sampled at tick 2300
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R6", "scoreboard drained", q.size(), 0);
    summary();
  end
endmodule